// File: doc/BRIEF.md
# Per-Line Protected Event Configuration Register Bank

This block is the register bank of an event and interrupt line controller. Each event line is described by one bit in each of six per-line registers: interrupt enable, event enable, rising-edge enable, falling-edge enable, software trigger and pending. Each line can be restricted to secure bus accesses, to privileged bus accesses, or to both. Two guard registers hold that choice, with one bit per line.

Every bus access carries a secure flag and a privileged flag. The block builds an access mask with one bit per line and applies it to each read and each write. A masked-off bit reads as zero, and a write leaves it unchanged. The two guard registers protect each other crosswise. A sticky lock bit can freeze both guard registers until the next reset. Edge detection and interrupt generation happen outside this block.

Top module: `evt_cfg_guard`

## Requirements
- R1: After a synchronous reset every register is zero, including the lock bit. Every line therefore starts non-secure and unprivileged, and `bus_rdata` is zero.
- R2: The register map is as follows: 0x0 interrupt enable, 0x1 event enable, 0x2 rising-edge enable, 0x3 falling-edge enable, 0x4 software trigger, 0x5 pending, 0x6 security guard, 0x7 privilege guard, 0x8 lock. For registers 0x0 to 0x4, a write takes the new value only in the bits whose line the access may touch. All other bits keep their old value.
- R3: A line whose security guard bit is 1 reads as 0 to a non-secure access, and a non-secure write to that line is dropped.
- R4: A line whose privilege guard bit is 1 reads as 0 to an unprivileged access, and an unprivileged write to that line is dropped.
- R5: The security guard register is visible only to secure accesses; a non-secure access reads 0 and its write is dropped. For a secure access, each bit is still masked by the privilege guard bit of the same line.
- R6: The privilege guard register is visible only to privileged accesses; an unprivileged access reads 0 and its write is dropped. For a privileged access, each bit is still masked by the security guard bit of the same line.
- R7: The lock register at 0x8 is visible only to secure accesses; bit 0 holds the lock. A secure write with data bit 0 at 1 sets the lock. No write can clear it. While the lock is set, writes to 0x6 and 0x7 are dropped, even when they are secure and privileged.
- R8: A permitted write of 1 to a pending bit clears that bit. A permitted write of 1 to a software trigger bit sets the matching pending bit.
- R9: A read of an unmapped address (0x9 to 0xF) returns 0, and a write to one changes no register.
- R10: Read data is registered. A read with `bus_rd` high shows its value, taken before any write in the same cycle, on `bus_rdata` one clock later. In a cycle after one without a read, `bus_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | NUM_LINES | Write data, one bit per line |
| bus_sec | input | 1 | Access is secure |
| bus_priv | input | 1 | Access is privileged |
| bus_rdata | output | NUM_LINES | Registered, masked read data |

## Verification
The assertions check on every cycle that a protected line never shows through a read to a disallowed access, and that a non-secure write never changes a secure line. They also check that the guard registers read zero to the wrong kind of access, that unmapped and idle reads return zero, that the lock never falls and that the guards stay frozen while it is set. Other behaviour can only be seen in the bench's scenarios. That includes the crosswise masking of one guard register by the other, the exact merged value after a partly permitted write, the software trigger setting pending bits, and write-one-to-clear on the permitted lines only.

// File: rtl/evt_cfg_pkg.sv
package evt_cfg_pkg;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_IE   = 4'h0,
    A_EE   = 4'h1,
    A_RISE = 4'h2,
    A_FALL = 4'h3,
    A_SWT  = 4'h4,
    A_PEND = 4'h5,
    A_SEC  = 4'h6,
    A_PRIV = 4'h7,
    A_LOCK = 4'h8
  } reg_sel_e;

  typedef struct packed {
    logic ie;
    logic ee;
    logic rise;
    logic fall;
    logic swt;
    logic pend;
    logic sec;
    logic priv;
    logic lock;
  } reg_hit_t;
endpackage

// File: rtl/evt_addr_decode.sv
module evt_addr_decode
  import evt_cfg_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output reg_hit_t          hit,
  output logic              line_hit,
  output logic              mapped
);
  always_comb begin
    hit = '0;
    case (addr)
      A_IE:    hit.ie   = 1'b1;
      A_EE:    hit.ee   = 1'b1;
      A_RISE:  hit.rise = 1'b1;
      A_FALL:  hit.fall = 1'b1;
      A_SWT:   hit.swt  = 1'b1;
      A_PEND:  hit.pend = 1'b1;
      A_SEC:   hit.sec  = 1'b1;
      A_PRIV:  hit.priv = 1'b1;
      A_LOCK:  hit.lock = 1'b1;
      default: hit = '0;
    endcase
  end

  assign line_hit = hit.ie | hit.ee | hit.rise | hit.fall | hit.swt | hit.pend;
  assign mapped   = |hit;
endmodule

// File: rtl/evt_access_mask.sv
module evt_access_mask #(
  parameter int NUM_LINES = 8
) (
  input  logic [NUM_LINES-1:0] sec_cfg,
  input  logic [NUM_LINES-1:0] priv_cfg,
  input  logic                 bus_sec,
  input  logic                 bus_priv,
  output logic [NUM_LINES-1:0] line_mask,
  output logic [NUM_LINES-1:0] sec_reg_mask,
  output logic [NUM_LINES-1:0] priv_reg_mask
);
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic sec_ok;
    logic priv_ok;
    assign sec_ok           = ~sec_cfg[i]  | bus_sec;
    assign priv_ok          = ~priv_cfg[i] | bus_priv;
    assign line_mask[i]     = sec_ok & priv_ok;
    // guard registers: whole register gated by one attribute, bits by the other
    assign sec_reg_mask[i]  = bus_sec  & priv_ok;
    assign priv_reg_mask[i] = bus_priv & sec_ok;
  end
endmodule

// File: rtl/evt_cfg_regs.sv
module evt_cfg_regs
  import evt_cfg_pkg::*;
#(
  parameter int NUM_LINES = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  reg_hit_t             hit,
  input  logic                 wr,
  input  logic                 bus_sec,
  input  logic [NUM_LINES-1:0] wdata,
  input  logic [NUM_LINES-1:0] line_mask,
  input  logic [NUM_LINES-1:0] sec_reg_mask,
  input  logic [NUM_LINES-1:0] priv_reg_mask,
  output logic [NUM_LINES-1:0] ie_q,
  output logic [NUM_LINES-1:0] ee_q,
  output logic [NUM_LINES-1:0] rise_q,
  output logic [NUM_LINES-1:0] fall_q,
  output logic [NUM_LINES-1:0] swt_q,
  output logic [NUM_LINES-1:0] pend_q,
  output logic [NUM_LINES-1:0] sec_q,
  output logic [NUM_LINES-1:0] priv_q,
  output logic                 lock_q
);
  function automatic logic [NUM_LINES-1:0] merge(
    input logic [NUM_LINES-1:0] old_v,
    input logic [NUM_LINES-1:0] new_v,
    input logic [NUM_LINES-1:0] m
  );
    return (old_v & ~m) | (new_v & m);
  endfunction

  logic [NUM_LINES-1:0] ones_ok;
  logic                 guard_wr_ok;

  assign ones_ok     = wdata & line_mask;
  assign guard_wr_ok = wr & ~lock_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q   <= '0;
      ee_q   <= '0;
      rise_q <= '0;
      fall_q <= '0;
      swt_q  <= '0;
      pend_q <= '0;
      sec_q  <= '0;
      priv_q <= '0;
      lock_q <= 1'b0;
    end else begin
      if (wr && hit.ie)   ie_q   <= merge(ie_q,   wdata, line_mask);
      if (wr && hit.ee)   ee_q   <= merge(ee_q,   wdata, line_mask);
      if (wr && hit.rise) rise_q <= merge(rise_q, wdata, line_mask);
      if (wr && hit.fall) fall_q <= merge(fall_q, wdata, line_mask);
      if (wr && hit.swt) begin
        swt_q  <= merge(swt_q, wdata, line_mask);
        pend_q <= pend_q | ones_ok;
      end
      if (wr && hit.pend) pend_q <= pend_q & ~ones_ok;
      if (guard_wr_ok && hit.sec)  sec_q  <= merge(sec_q,  wdata, sec_reg_mask);
      if (guard_wr_ok && hit.priv) priv_q <= merge(priv_q, wdata, priv_reg_mask);
      if (wr && hit.lock && bus_sec && wdata[0]) lock_q <= 1'b1;
    end
  end

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> lock_q); // R7
  AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> ($stable(sec_q) && $stable(priv_q))); // R7
  AST_NS_WRITE_DROP: assert property (@(posedge clk) disable iff (rst)
    (wr && !bus_sec && hit.ie) |=> (((ie_q ^ $past(ie_q)) & $past(sec_q)) == '0)); // R3
  AST_PEND_CLEAR_ONLY: assert property (@(posedge clk) disable iff (rst)
    (wr && hit.pend) |=> ((pend_q & ~$past(pend_q)) == '0)); // R8
endmodule

// File: rtl/evt_cfg_guard.sv
module evt_cfg_guard
  import evt_cfg_pkg::*;
#(
  parameter int NUM_LINES = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [3:0]           bus_addr,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [NUM_LINES-1:0] bus_wdata,
  input  logic                 bus_sec,
  input  logic                 bus_priv,
  output logic [NUM_LINES-1:0] bus_rdata
);
  reg_hit_t             hit;
  logic                 line_hit;
  logic                 mapped;
  logic [NUM_LINES-1:0] line_mask, sec_reg_mask, priv_reg_mask;
  logic [NUM_LINES-1:0] ie_q, ee_q, rise_q, fall_q, swt_q, pend_q, sec_q, priv_q;
  logic                 lock_q;
  logic [NUM_LINES-1:0] rd_mux;

  evt_addr_decode u_dec (
    .addr     (bus_addr),
    .hit      (hit),
    .line_hit (line_hit),
    .mapped   (mapped)
  );

  evt_access_mask #(.NUM_LINES(NUM_LINES)) u_mask (
    .sec_cfg       (sec_q),
    .priv_cfg      (priv_q),
    .bus_sec       (bus_sec),
    .bus_priv      (bus_priv),
    .line_mask     (line_mask),
    .sec_reg_mask  (sec_reg_mask),
    .priv_reg_mask (priv_reg_mask)
  );

  evt_cfg_regs #(.NUM_LINES(NUM_LINES)) u_regs (
    .clk           (clk),
    .rst           (rst),
    .hit           (hit),
    .wr            (bus_wr),
    .bus_sec       (bus_sec),
    .wdata         (bus_wdata),
    .line_mask     (line_mask),
    .sec_reg_mask  (sec_reg_mask),
    .priv_reg_mask (priv_reg_mask),
    .ie_q          (ie_q),
    .ee_q          (ee_q),
    .rise_q        (rise_q),
    .fall_q        (fall_q),
    .swt_q         (swt_q),
    .pend_q        (pend_q),
    .sec_q         (sec_q),
    .priv_q        (priv_q),
    .lock_q        (lock_q)
  );

  always_comb begin
    rd_mux = '0;
    if (hit.ie)   rd_mux = ie_q   & line_mask;
    if (hit.ee)   rd_mux = ee_q   & line_mask;
    if (hit.rise) rd_mux = rise_q & line_mask;
    if (hit.fall) rd_mux = fall_q & line_mask;
    if (hit.swt)  rd_mux = swt_q  & line_mask;
    if (hit.pend) rd_mux = pend_q & line_mask;
    if (hit.sec)  rd_mux = sec_q  & sec_reg_mask;
    if (hit.priv) rd_mux = priv_q & priv_reg_mask;
    if (hit.lock) rd_mux = {{(NUM_LINES-1){1'b0}}, lock_q & bus_sec};
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
    else             bus_rdata <= '0;
  end

  AST_SEC_LINE_HIDDEN: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && line_hit && !bus_sec) |=> ((bus_rdata & $past(sec_q)) == '0)); // R3
  AST_PRIV_LINE_HIDDEN: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && line_hit && !bus_priv) |=> ((bus_rdata & $past(priv_q)) == '0)); // R4
  AST_SEC_REG_NS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == A_SEC && !bus_sec) |=> (bus_rdata == '0)); // R5
  AST_PRIV_REG_UP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == A_PRIV && !bus_priv) |=> (bus_rdata == '0)); // R6
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !mapped) |=> (bus_rdata == '0)); // R9
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == '0)); // R10
endmodule

// File: tb/evt_cfg_guard_bench.sv
module evt_cfg_guard_bench;
  localparam int NL = 8;

  typedef struct packed {
    logic [3:0]    a;
    logic          wr;
    logic          rd;
    logic          s;
    logic          p;
    logic [NL-1:0] wd;
    logic [NL-1:0] ex;
    logic [3:0]    rq;
  } vec_t;

  localparam int NV = 41;
  localparam vec_t VT [NV] = '{
    '{4'h0,1'b1,1'b0,1'b0,1'b0,8'hA5,8'h00,4'd2},  // R2 open write
    '{4'h0,1'b0,1'b1,1'b0,1'b0,8'h00,8'hA5,4'd2},  // R2
    '{4'h6,1'b1,1'b0,1'b1,1'b1,8'h0F,8'h00,4'd5},  // R5 lines 0-3 secure
    '{4'h6,1'b0,1'b1,1'b1,1'b1,8'h00,8'h0F,4'd5},  // R5
    '{4'h6,1'b0,1'b1,1'b0,1'b1,8'h00,8'h00,4'd5},  // R5 non-secure sees 0
    '{4'h0,1'b0,1'b1,1'b0,1'b0,8'h00,8'hA0,4'd3},  // R3 masked read
    '{4'h0,1'b0,1'b1,1'b1,1'b0,8'h00,8'hA5,4'd3},  // R3
    '{4'h0,1'b1,1'b0,1'b0,1'b0,8'h00,8'h00,4'd3},  // R3 partial write
    '{4'h0,1'b0,1'b1,1'b1,1'b1,8'h00,8'h05,4'd3},  // R3
    '{4'h7,1'b1,1'b0,1'b1,1'b1,8'h30,8'h00,4'd6},  // R6 lines 4-5 privileged
    '{4'h7,1'b0,1'b1,1'b0,1'b1,8'h00,8'h30,4'd6},  // R6 masked by security
    '{4'h7,1'b0,1'b1,1'b1,1'b0,8'h00,8'h00,4'd6},  // R6 unprivileged sees 0
    '{4'h1,1'b1,1'b0,1'b1,1'b0,8'hFF,8'h00,4'd4},  // R4 unpriv write
    '{4'h1,1'b0,1'b1,1'b1,1'b1,8'h00,8'hCF,4'd4},  // R4
    '{4'h1,1'b0,1'b1,1'b0,1'b1,8'h00,8'hC0,4'd4},  // R3
    '{4'h6,1'b1,1'b0,1'b1,1'b0,8'hFF,8'h00,4'd5},  // R5 crosswise mask
    '{4'h6,1'b0,1'b1,1'b1,1'b1,8'h00,8'hCF,4'd5},  // R5
    '{4'h7,1'b1,1'b0,1'b0,1'b1,8'h00,8'h00,4'd6},  // R6 crosswise mask
    '{4'h7,1'b0,1'b1,1'b1,1'b1,8'h00,8'h00,4'd6},  // R6
    '{4'h4,1'b1,1'b0,1'b1,1'b1,8'h33,8'h00,4'd8},  // R8 trigger
    '{4'h5,1'b0,1'b1,1'b1,1'b1,8'h00,8'h33,4'd8},  // R8
    '{4'h5,1'b1,1'b0,1'b0,1'b0,8'hFF,8'h00,4'd8},  // R8 clear, non-secure
    '{4'h5,1'b0,1'b1,1'b1,1'b1,8'h00,8'h03,4'd8},  // R8
    '{4'hC,1'b0,1'b1,1'b1,1'b1,8'h00,8'h00,4'd9},  // R9
    '{4'hC,1'b1,1'b0,1'b1,1'b1,8'hFF,8'h00,4'd9},  // R9
    '{4'h0,1'b0,1'b1,1'b1,1'b1,8'h00,8'h05,4'd9},  // R9 unchanged
    '{4'h8,1'b1,1'b0,1'b0,1'b1,8'h01,8'h00,4'd7},  // R7 non-secure lock try
    '{4'h8,1'b0,1'b1,1'b1,1'b1,8'h00,8'h00,4'd7},  // R7
    '{4'h8,1'b1,1'b0,1'b1,1'b0,8'h01,8'h00,4'd7},  // R7 lock
    '{4'h8,1'b0,1'b1,1'b1,1'b0,8'h00,8'h01,4'd7},  // R7
    '{4'h8,1'b0,1'b1,1'b0,1'b1,8'h00,8'h00,4'd7},  // R7 hidden
    '{4'h8,1'b1,1'b0,1'b1,1'b1,8'h00,8'h00,4'd7},  // R7 clear try
    '{4'h8,1'b0,1'b1,1'b1,1'b1,8'h00,8'h01,4'd7},  // R7 still set
    '{4'h6,1'b1,1'b0,1'b1,1'b1,8'h00,8'h00,4'd7},  // R7 frozen
    '{4'h6,1'b0,1'b1,1'b1,1'b1,8'h00,8'hCF,4'd7},  // R7
    '{4'h7,1'b1,1'b0,1'b1,1'b1,8'hFF,8'h00,4'd7},  // R7 frozen
    '{4'h7,1'b0,1'b1,1'b1,1'b1,8'h00,8'h00,4'd7},  // R7
    '{4'h2,1'b1,1'b0,1'b1,1'b1,8'hFF,8'h00,4'd2},  // R2
    '{4'h2,1'b0,1'b1,1'b0,1'b0,8'h00,8'h30,4'd3},  // R3
    '{4'h3,1'b1,1'b0,1'b0,1'b0,8'h5A,8'h00,4'd2},  // R2 partial
    '{4'h3,1'b0,1'b1,1'b1,1'b1,8'h00,8'h10,4'd2}   // R2
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [3:0]    bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [NL-1:0] bus_wdata = '0;
  logic          bus_sec = 1'b0;
  logic          bus_priv = 1'b0;
  logic [NL-1:0] bus_rdata;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  evt_cfg_guard #(.NUM_LINES(NL)) u_evt_cfg_guard (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_sec   (bus_sec),
    .bus_priv  (bus_priv),
    .bus_rdata (bus_rdata)
  );

  task automatic check(input logic [NL-1:0] exp, input int rq);
    n_tests++;
    if (bus_rdata !== exp) begin
      n_fail++;
      $display("FAIL R%0d: rdata=%h expected=%h", rq, bus_rdata, exp);
    end
  endtask

  task automatic op(input vec_t v);
    @(negedge clk);
    bus_addr  = v.a;
    bus_wr    = v.wr;
    bus_rd    = v.rd;
    bus_wdata = v.wd;
    bus_sec   = v.s;
    bus_priv  = v.p;
    @(posedge clk);
    #1;
    check(v.rd ? v.ex : '0, v.rd ? int'(v.rq) : 10); // R10 when idle
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check('0, 1); // R1 rdata after reset
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) op(VT[i]);
    // R10: registered, old value before same-cycle write
    op('{4'h1,1'b1,1'b1,1'b1,1'b1,8'h00,8'hCF,4'd10});
    op('{4'h1,1'b0,1'b1,1'b1,1'b1,8'h00,8'h00,4'd10});
    // R1: reset clears lock, guards and line registers
    @(negedge clk);
    bus_wr = 1'b0;
    bus_rd = 1'b0;
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    op('{4'h8,1'b0,1'b1,1'b1,1'b1,8'h00,8'h00,4'd1});
    op('{4'h6,1'b0,1'b1,1'b1,1'b1,8'h00,8'h00,4'd1});
    op('{4'h0,1'b0,1'b1,1'b1,1'b1,8'h00,8'h00,4'd1});
    op('{4'h6,1'b1,1'b0,1'b1,1'b1,8'h77,8'h00,4'd1});
    op('{4'h6,1'b0,1'b1,1'b1,1'b1,8'h00,8'h77,4'd1});
    @(negedge clk);
    bus_wr = 1'b0;
    bus_rd = 1'b0;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule